// File: doc/BRIEF.md
# Rectangular Pixel Fill and Copy Engine

This engine writes a rectangle of pixels into a frame buffer held in a synchronous memory. It has two supported jobs. A fill writes one constant colour into every pixel of the rectangle. A copy reads pixels from a source buffer and writes them to a destination buffer, either unchanged or converted between pixel formats. Pixels are 32-bit ARGB8888, 16-bit RGB565 or 16-bit ARGB4444. A fill colour is given as 0xAARRGGBB and is repacked to the destination format before it is written.

Software clips the rectangle first. It then loads the first-pixel byte addresses (computed as base + (y*stride + x)*bytes_per_pixel), the number of pixels to skip at each line end (stride minus width), the rectangle size, the colour and the formats. Writing the start bit launches the job. The start bit reads 1 until the engine is idle again, and `done_o` pulses once at the end of each job. The memory side has a read port with one cycle of latency, a write port with byte enables, and 32-bit word-aligned addresses. A 16-bit pixel occupies the halfword picked by bit 1 of its byte address.

Register word index (`reg_addr_i`):

| Index | Content |
|-------|---------|
| 0 | control: bit 0 start (reads busy), bits [5:4] mode |
| 1 | size: bits [31:16] pixels per line, bits [15:0] lines |
| 2 | destination first-pixel byte address |
| 3 | destination skip, in pixels, bits [15:0] |
| 4 | source first-pixel byte address |
| 5 | source skip, in pixels, bits [15:0] |
| 6 | fill colour 0xAARRGGBB |
| 7 | formats: bits [1:0] destination, bits [9:8] source |

Top module: `pix2d_engine`

## Requirements
- R1: After reset, every register reads 0, `done_o` is 0, and no memory read or write is issued.
- R2: Control bit 0 reads 1 from the cycle after a start write until the job ends, and reads 0 when the engine is idle. Writing the start bit while the engine is busy is ignored.
- R3: The size register holds the pixels per line in bits [31:16] and the line count in bits [15:0]. A job makes exactly width*height memory writes.
- R4: Within a line, each address advances by the pixel size: 4 bytes for format 0 (ARGB8888) and 2 bytes for format 1 (RGB565) or format 2 (ARGB4444). After the last pixel of a line, the address advances by a further skip*pixel size. The source and destination addresses step independently, each with its own skip.
- R5: Mode 3 (fill) into a 32-bit destination writes the colour register unchanged.
- R6: Mode 3 into RGB565 writes colour[23:19]<<11 | colour[15:10]<<5 | colour[7:3].
- R7: Mode 3 into ARGB4444 writes colour[23:20]<<8 | colour[15:12]<<4 | colour[7:4], with the alpha nibble 0.
- R8: Mode 0 (copy) moves each pixel unchanged. The source pixel size follows the destination format.
- R9: Mode 1 (convert) reads pixels in the source format. A 32-bit pixel narrows to RGB565 as p[23:19],p[15:10],p[7:3], or to ARGB4444 as p[31:28],p[23:20],p[15:12],p[7:4]. A 16-bit pixel widens to 32 bits by repeating each channel's top bits into its low bits, and RGB565 gets alpha 0xFF.
- R10: A start with zero width, zero lines or mode 2 makes no memory access. `done_o` then pulses in the cycle after the start write has been registered.
- R11: A 16-bit pixel write enables only the two byte lanes of its halfword (bits [31:16] when address bit 1 is 1). The other halfword of the word is left unchanged.
- R12: The job uses the register values captured at start, so writes made during the job do not change it. `done_o` is high for one cycle, width*height+2 cycles after the cycle in which the start write was registered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| reg_we_i | input | 1 | register write strobe |
| reg_addr_i | input | 3 | register word index |
| reg_wdata_i | input | 32 | register write data |
| reg_rdata_o | output | 32 | register read data (combinational) |
| done_o | output | 1 | one-cycle end-of-job pulse |
| rd_en_o | output | 1 | memory read request |
| rd_addr_o | output | ADDR_W | memory read address, word aligned |
| rd_data_i | input | 32 | memory read data, one cycle after the request |
| wr_en_o | output | 1 | memory write request |
| wr_addr_o | output | ADDR_W | memory write address, word aligned |
| wr_data_o | output | 32 | memory write data |
| wr_be_o | output | 4 | memory write byte enables |

## Verification
The bench places rectangles so that pixels outside them sit right next to written ones: line-end gaps in strided buffers, and 16-bit pixels whose word partner belongs to another column. This exposes a wrong skip step, an off-by-one line end, or a byte-enable fault that clobbers the neighbouring halfword. Every 16-bit channel fill and conversion uses colours with distinct bits per channel, so a shifted bit slice or a lost alpha rule gives a wrong memory word. Zero-width, zero-height and blend starts must finish without any write, and a second start issued mid-job must be dropped, so a design that fails to capture its registers shows extra or altered writes. The cycle count from start to `done_o` is checked, which catches a missing or extra pipeline stage.

// File: rtl/pix2d_pkg.sv
package pix2d_pkg;
  localparam int DIM_W = 16;

  typedef enum logic [1:0] {
    MODE_COPY  = 2'd0,
    MODE_CONV  = 2'd1,
    MODE_BLEND = 2'd2,
    MODE_FILL  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    FMT_ARGB8888 = 2'd0,
    FMT_RGB565   = 2'd1,
    FMT_ARGB4444 = 2'd2,
    FMT_RSVD     = 2'd3
  } fmt_e;

  function automatic logic fmt_is16(input fmt_e f);
    return (f == FMT_RGB565) || (f == FMT_ARGB4444);
  endfunction

  function automatic logic [15:0] narrow_565(input logic [31:0] c);
    return {c[23:19], c[15:10], c[7:3]};
  endfunction

  function automatic logic [15:0] narrow_4444(input logic [31:0] c, input logic keep_a);
    return {(keep_a ? c[31:28] : 4'h0), c[23:20], c[15:12], c[7:4]};
  endfunction

  function automatic logic [31:0] widen_565(input logic [15:0] p);
    return {8'hff, p[15:11], p[15:13], p[10:5], p[10:9], p[4:0], p[4:2]};
  endfunction

  function automatic logic [31:0] widen_4444(input logic [15:0] p);
    return {p[15:12], p[15:12], p[11:8], p[11:8], p[7:4], p[7:4], p[3:0], p[3:0]};
  endfunction
endpackage

// File: rtl/pix2d_regs.sv
module pix2d_regs
  import pix2d_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              busy_i,
  output logic [31:0]       reg_rdata_o,
  output logic              start_o,
  output mode_e             mode_o,
  output logic [DIM_W-1:0]  width_o,
  output logic [DIM_W-1:0]  height_o,
  output logic [ADDR_W-1:0] dst_base_o,
  output logic [DIM_W-1:0]  dst_skip_o,
  output logic [ADDR_W-1:0] src_base_o,
  output logic [DIM_W-1:0]  src_skip_o,
  output logic [31:0]       colour_o,
  output fmt_e              dst_fmt_o,
  output fmt_e              src_fmt_o
);
  localparam logic [2:0] IDX_CTRL = 3'd0, IDX_SIZE = 3'd1, IDX_DBASE = 3'd2,
                         IDX_DSKIP = 3'd3, IDX_SBASE = 3'd4, IDX_SSKIP = 3'd5,
                         IDX_COL = 3'd6, IDX_FMT = 3'd7;

  mode_e             mode_q;
  logic [31:0]       size_q;
  logic [ADDR_W-1:0] dbase_q, sbase_q;
  logic [DIM_W-1:0]  dskip_q, sskip_q;
  logic [31:0]       col_q;
  fmt_e              dfmt_q, sfmt_q;
  logic              start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_COPY;
      size_q  <= '0;
      dbase_q <= '0;
      sbase_q <= '0;
      dskip_q <= '0;
      sskip_q <= '0;
      col_q   <= '0;
      dfmt_q  <= FMT_ARGB8888;
      sfmt_q  <= FMT_ARGB8888;
      start_q <= 1'b0;
    end else begin
      start_q <= reg_we_i && (reg_addr_i == IDX_CTRL) && reg_wdata_i[0] && !busy_i;
      if (reg_we_i) begin
        unique case (reg_addr_i)
          IDX_CTRL:  mode_q  <= mode_e'(reg_wdata_i[5:4]);
          IDX_SIZE:  size_q  <= reg_wdata_i;
          IDX_DBASE: dbase_q <= reg_wdata_i[ADDR_W-1:0];
          IDX_DSKIP: dskip_q <= reg_wdata_i[DIM_W-1:0];
          IDX_SBASE: sbase_q <= reg_wdata_i[ADDR_W-1:0];
          IDX_SSKIP: sskip_q <= reg_wdata_i[DIM_W-1:0];
          IDX_COL:   col_q   <= reg_wdata_i;
          IDX_FMT: begin
            dfmt_q <= fmt_e'(reg_wdata_i[1:0]);
            sfmt_q <= fmt_e'(reg_wdata_i[9:8]);
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      IDX_CTRL: begin
        reg_rdata_o[5:4] = mode_q;
        reg_rdata_o[0]   = busy_i;
      end
      IDX_SIZE:  reg_rdata_o = size_q;
      IDX_DBASE: reg_rdata_o[ADDR_W-1:0] = dbase_q;
      IDX_DSKIP: reg_rdata_o[DIM_W-1:0] = dskip_q;
      IDX_SBASE: reg_rdata_o[ADDR_W-1:0] = sbase_q;
      IDX_SSKIP: reg_rdata_o[DIM_W-1:0] = sskip_q;
      IDX_COL:   reg_rdata_o = col_q;
      IDX_FMT: begin
        reg_rdata_o[1:0] = dfmt_q;
        reg_rdata_o[9:8] = sfmt_q;
      end
      default: ;
    endcase
  end

  assign start_o    = start_q;
  assign mode_o     = mode_q;
  assign width_o    = size_q[31:16];
  assign height_o   = size_q[15:0];
  assign dst_base_o = dbase_q;
  assign dst_skip_o = dskip_q;
  assign src_base_o = sbase_q;
  assign src_skip_o = sskip_q;
  assign colour_o   = col_q;
  assign dst_fmt_o  = dfmt_q;
  assign src_fmt_o  = sfmt_q;

  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> !$past(busy_i)); // R2
endmodule

// File: rtl/pix2d_walker.sv
module pix2d_walker
  import pix2d_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mode_e             mode_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  input  logic [DIM_W-1:0]  dst_skip_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [DIM_W-1:0]  src_skip_i,
  input  logic [31:0]       colour_i,
  input  fmt_e              dst_fmt_i,
  input  fmt_e              src_fmt_i,
  output logic              active_o,
  output logic              empty_o,
  output logic              last_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic [ADDR_W-1:0] src_addr_o,
  output mode_e             job_mode_o,
  output fmt_e              job_dst_fmt_o,
  output fmt_e              job_src_fmt_o,
  output logic [31:0]       job_colour_o
);
  localparam int PAD_W = ADDR_W - DIM_W;

  logic              active_q;
  logic [DIM_W-1:0]  x_q, y_q, w_q, h_q, dskip_q, sskip_q;
  logic [ADDR_W-1:0] dst_q, src_q;
  mode_e             mode_q;
  fmt_e              dfmt_q, sfmt_q;
  logic [31:0]       col_q;

  logic              empty, x_end, y_end;
  logic [1:0]        dsh, ssh;
  logic [ADDR_W-1:0] dst_px, src_px, dst_line, src_line;

  assign empty = (width_i == '0) || (height_i == '0) || (mode_i == MODE_BLEND);
  assign x_end = (x_q == w_q - 1'b1);
  assign y_end = (y_q == h_q - 1'b1);

  // pixel size as a shift: 1 -> 2 bytes, 2 -> 4 bytes
  assign dsh = fmt_is16(dfmt_q) ? 2'd1 : 2'd2;
  assign ssh = (mode_q == MODE_CONV) ? (fmt_is16(sfmt_q) ? 2'd1 : 2'd2) : dsh;

  assign dst_px   = ADDR_W'(1) << dsh;
  assign src_px   = ADDR_W'(1) << ssh;
  assign dst_line = ({{PAD_W{1'b0}}, dskip_q} + ADDR_W'(1)) << dsh;
  assign src_line = ({{PAD_W{1'b0}}, sskip_q} + ADDR_W'(1)) << ssh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      x_q      <= '0;
      y_q      <= '0;
      w_q      <= '0;
      h_q      <= '0;
      dskip_q  <= '0;
      sskip_q  <= '0;
      dst_q    <= '0;
      src_q    <= '0;
      mode_q   <= MODE_COPY;
      dfmt_q   <= FMT_ARGB8888;
      sfmt_q   <= FMT_ARGB8888;
      col_q    <= '0;
    end else if (start_i && !empty) begin
      active_q <= 1'b1;
      x_q      <= '0;
      y_q      <= '0;
      w_q      <= width_i;
      h_q      <= height_i;
      dskip_q  <= dst_skip_i;
      sskip_q  <= src_skip_i;
      dst_q    <= dst_base_i;
      src_q    <= src_base_i;
      mode_q   <= mode_i;
      dfmt_q   <= dst_fmt_i;
      sfmt_q   <= src_fmt_i;
      col_q    <= colour_i;
    end else if (active_q) begin
      if (x_end) begin
        x_q   <= '0;
        y_q   <= y_q + 1'b1;
        dst_q <= dst_q + dst_line;
        src_q <= src_q + src_line;
        if (y_end) active_q <= 1'b0;
      end else begin
        x_q   <= x_q + 1'b1;
        dst_q <= dst_q + dst_px;
        src_q <= src_q + src_px;
      end
    end
  end

  assign active_o      = active_q;
  assign empty_o       = start_i && empty;
  assign last_o        = active_q && x_end && y_end;
  assign rd_en_o       = active_q && (mode_q != MODE_FILL);
  assign dst_addr_o    = dst_q;
  assign src_addr_o    = src_q;
  assign job_mode_o    = mode_q;
  assign job_dst_fmt_o = dfmt_q;
  assign job_src_fmt_o = sfmt_q;
  assign job_colour_o  = col_q;

  AST_EMPTY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && empty && !active_q) |=> !active_q); // R10
  AST_START_HOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !empty) |=> (dst_q == $past(dst_base_i)) && (x_q == '0) && (y_q == '0)); // R4
endmodule

// File: rtl/pix2d_pixel.sv
module pix2d_pixel
  import pix2d_pkg::*;
(
  input  mode_e       mode_i,
  input  fmt_e        dst_fmt_i,
  input  fmt_e        src_fmt_i,
  input  logic [31:0] colour_i,
  input  logic [31:0] rd_data_i,
  input  logic        src_lane_i,
  output logic [31:0] pixel_o
);
  logic [15:0] half;
  logic [31:0] src_wide;
  logic [31:0] conv_px, copy_px, fill_px;

  assign half = src_lane_i ? rd_data_i[31:16] : rd_data_i[15:0];

  always_comb begin
    unique case (src_fmt_i)
      FMT_RGB565:   src_wide = widen_565(half);
      FMT_ARGB4444: src_wide = widen_4444(half);
      default:      src_wide = rd_data_i;
    endcase
  end

  always_comb begin
    unique case (dst_fmt_i)
      FMT_RGB565: begin
        conv_px = {16'h0, narrow_565(src_wide)};
        fill_px = {16'h0, narrow_565(colour_i)};
      end
      FMT_ARGB4444: begin
        conv_px = {16'h0, narrow_4444(src_wide, 1'b1)};
        fill_px = {16'h0, narrow_4444(colour_i, 1'b0)};
      end
      default: begin
        conv_px = src_wide;
        fill_px = colour_i;
      end
    endcase
  end

  assign copy_px = fmt_is16(dst_fmt_i) ? {16'h0, half} : rd_data_i;

  always_comb begin
    unique case (mode_i)
      MODE_FILL: pixel_o = fill_px;
      MODE_CONV: pixel_o = conv_px;
      default:   pixel_o = copy_px;
    endcase
  end
endmodule

// File: rtl/pix2d_engine.sv
module pix2d_engine
  import pix2d_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              done_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [31:0]       rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [31:0]       wr_data_o,
  output logic [3:0]        wr_be_o
);
  logic              start, busy, active, empty_start, beat_last, beat_rd;
  mode_e             cfg_mode, job_mode;
  fmt_e              cfg_dfmt, cfg_sfmt, job_dfmt, job_sfmt;
  logic [DIM_W-1:0]  cfg_w, cfg_h, cfg_dskip, cfg_sskip;
  logic [ADDR_W-1:0] cfg_dbase, cfg_sbase, beat_dst, beat_src;
  logic [31:0]       cfg_col, job_col, pixel;

  logic              w_valid_q, w_last_q, w_lane_q, done_q;
  logic [ADDR_W-1:0] w_dst_q;

  assign busy = start | active | w_valid_q;

  pix2d_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .busy_i(busy), .reg_rdata_o, .start_o(start), .mode_o(cfg_mode),
    .width_o(cfg_w), .height_o(cfg_h), .dst_base_o(cfg_dbase),
    .dst_skip_o(cfg_dskip), .src_base_o(cfg_sbase), .src_skip_o(cfg_sskip),
    .colour_o(cfg_col), .dst_fmt_o(cfg_dfmt), .src_fmt_o(cfg_sfmt)
  );

  pix2d_walker #(.ADDR_W(ADDR_W)) u_walker (
    .clk_i, .rst_ni, .start_i(start), .mode_i(cfg_mode),
    .width_i(cfg_w), .height_i(cfg_h), .dst_base_i(cfg_dbase),
    .dst_skip_i(cfg_dskip), .src_base_i(cfg_sbase), .src_skip_i(cfg_sskip),
    .colour_i(cfg_col), .dst_fmt_i(cfg_dfmt), .src_fmt_i(cfg_sfmt),
    .active_o(active), .empty_o(empty_start), .last_o(beat_last),
    .rd_en_o(beat_rd), .dst_addr_o(beat_dst), .src_addr_o(beat_src),
    .job_mode_o(job_mode), .job_dst_fmt_o(job_dfmt),
    .job_src_fmt_o(job_sfmt), .job_colour_o(job_col)
  );

  assign rd_en_o   = beat_rd;
  assign rd_addr_o = {beat_src[ADDR_W-1:2], 2'b00};

  // write stage: aligns with the one-cycle read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_valid_q <= 1'b0;
      w_last_q  <= 1'b0;
      w_lane_q  <= 1'b0;
      w_dst_q   <= '0;
      done_q    <= 1'b0;
    end else begin
      w_valid_q <= active;
      w_last_q  <= beat_last;
      w_lane_q  <= beat_src[1];
      w_dst_q   <= beat_dst;
      done_q    <= (w_valid_q && w_last_q) || empty_start;
    end
  end

  pix2d_pixel u_pixel (
    .mode_i(job_mode), .dst_fmt_i(job_dfmt), .src_fmt_i(job_sfmt),
    .colour_i(job_col), .rd_data_i, .src_lane_i(w_lane_q), .pixel_o(pixel)
  );

  logic dst16;
  assign dst16     = fmt_is16(job_dfmt);
  assign wr_en_o   = w_valid_q;
  assign wr_addr_o = {w_dst_q[ADDR_W-1:2], 2'b00};
  assign wr_data_o = dst16 ? {pixel[15:0], pixel[15:0]} : pixel;

  for (genvar g = 0; g < 4; g++) begin : g_be
    assign wr_be_o[g] = w_valid_q && (!dst16 || (w_dst_q[1] == g[1]));
  end

  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !wr_en_o && !rd_en_o); // R10
  AST_HALF_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && dst16) |-> ($countones(wr_be_o) == 2) && (wr_be_o[0] == wr_be_o[1])); // R11
  AST_READ_FEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && job_mode != MODE_FILL) |-> $past(rd_en_o)); // R8
  AST_FILL_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && job_mode == MODE_FILL) |-> !rd_en_o); // R5
endmodule

// File: tb/pix2d_engine_tb.sv
module pix2d_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        done;
  logic        rd_en, wr_en;
  logic [31:0] rd_addr, wr_addr, wr_data, rd_q;
  logic [3:0]  wr_be;

  logic [31:0] mem  [1024];
  logic [31:0] gold [1024];
  int checks = 0, fails = 0, wr_cnt = 0;

  always #5 clk = ~clk;

  pix2d_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .done_o(done),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_q),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_be_o(wr_be)
  );

  always @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr[11:2]];
    if (wr_en) begin
      for (int b = 0; b < 4; b++)
        if (wr_be[b]) mem[wr_addr[11:2]][8*b +: 8] <= wr_data[8*b +: 8];
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] e565(input logic [31:0] c);
    return {c[23:19], c[15:10], c[7:3]};
  endfunction
  function automatic logic [15:0] e4444(input logic [31:0] c, input bit a);
    return {a ? c[31:28] : 4'h0, c[23:20], c[15:12], c[7:4]};
  endfunction
  function automatic logic [31:0] w565(input logic [15:0] p);
    return {8'hff, p[15:11], p[15:13], p[10:5], p[10:9], p[4:0], p[4:2]};
  endfunction
  function automatic logic [31:0] w4444(input logic [15:0] p);
    return {p[15:12], p[15:12], p[11:8], p[11:8], p[7:4], p[7:4], p[3:0], p[3:0]};
  endfunction

  task automatic init_mem();
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = {i[7:0] ^ 8'h5a, ~i[7:0], i[15:0] * 16'd37 + 16'h1234};
      gold[i] = mem[i];
    end
  endtask

  function automatic logic [31:0] get_px(input int a, input bit is16);
    if (!is16) return mem[a >> 2];
    return a[1] ? {16'h0, mem[a >> 2][31:16]} : {16'h0, mem[a >> 2][15:0]};
  endfunction

  task automatic put_gold(input int a, input bit is16, input logic [31:0] v);
    if (!is16) gold[a >> 2] = v;
    else if (a[1]) gold[a >> 2][31:16] = v[15:0];
    else gold[a >> 2][15:0] = v[15:0];
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < 1024; i++)
      if (mem[i] !== gold[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (bad != 0) $display("  first differing word %0d: %h vs %h", first, mem[first], gold[first]);
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // programs every field, then writes the start bit
  task automatic launch(input int mode, input int w, input int h,
                        input int dbase, input int dskip, input int sbase, input int sskip,
                        input logic [31:0] col, input int dfmt, input int sfmt);
    reg_wr(3'd1, (w << 16) | h);
    reg_wr(3'd2, dbase);
    reg_wr(3'd3, dskip);
    reg_wr(3'd4, sbase);
    reg_wr(3'd5, sskip);
    reg_wr(3'd6, col);
    reg_wr(3'd7, (sfmt << 8) | dfmt);
    wr_cnt = 0;
    reg_wr(3'd0, (mode << 4) | 1);
  endtask

  // expected image from (y*stride + x)*bytes addressing
  task automatic model(input int mode, input int w, input int h,
                       input int dbase, input int dstride, input int sbase, input int sstride,
                       input logic [31:0] col, input int dfmt, input int sfmt);
    bit d16 = (dfmt == 1) || (dfmt == 2);
    bit s16 = (mode == 1) ? ((sfmt == 1) || (sfmt == 2)) : d16;
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        int da = dbase + (y * dstride + x) * (d16 ? 2 : 4);
        int sa = sbase + (y * sstride + x) * (s16 ? 2 : 4);
        logic [31:0] v, s;
        s = get_px(sa, s16);
        if (mode == 3) v = (dfmt == 1) ? {16'h0, e565(col)} : (dfmt == 2) ? {16'h0, e4444(col, 1'b0)} : col;
        else if (mode == 0) v = s;
        else begin
          logic [31:0] wd;
          wd = (sfmt == 1) ? w565(s[15:0]) : (sfmt == 2) ? w4444(s[15:0]) : s;
          v = (dfmt == 1) ? {16'h0, e565(wd)} : (dfmt == 2) ? {16'h0, e4444(wd, 1'b1)} : wd;
        end
        put_gold(da, d16, v);
      end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      reg_rd(3'(i), d);
      chk(d == 0, "R1 register reset value", d, 0);
    end
    chk(!done && !wr_en && !rd_en, "R1 idle outputs", {done, wr_en, rd_en}, 0);
  endtask

  task automatic t_fill32();
    int n;
    logic [31:0] d;
    init_mem();
    model(3, 3, 2, 'h100, 8, 0, 0, 32'h12345678, 0, 0);
    launch(3, 3, 2, 'h100, 5, 0, 0, 32'h12345678, 0, 0);
    wait_done(n);
    chk(n == 8, "R12 start-to-done cycles", n, 8);
    @(negedge clk);
    chk(!done, "R12 done lasts one cycle", done, 0);
    chk(wr_cnt == 6, "R3 write count", wr_cnt, 6);
    cmp_mem("R5 R4 fill32 image");
    reg_rd(3'd0, d);
    chk(d == 32'h30, "R2 idle control readback", d, 32'h30);
  endtask

  task automatic t_fill16(input int fmt, input logic [31:0] col, input int base,
                          input int w, input int h, input int stride, input string req);
    int n;
    init_mem();
    model(3, w, h, base, stride, 0, 0, col, fmt, 0);
    launch(3, w, h, base, stride - w, 0, 0, col, fmt, 0);
    wait_done(n);
    chk(wr_cnt == w * h, "R3 write count 16-bit fill", wr_cnt, w * h);
    cmp_mem(req);
  endtask

  task automatic t_copy32();
    int n;
    logic [31:0] d;
    init_mem();
    model(0, 3, 3, 'h400, 7, 'h000, 5, 0, 0, 0);
    launch(0, 3, 3, 'h400, 4, 'h000, 2, 0, 0, 0);
    reg_rd(3'd0, d);
    chk(d[0] == 1'b1, "R2 busy during job", d[0], 1);
    wait_done(n);
    chk(wr_cnt == 9, "R3 copy write count", wr_cnt, 9);
    cmp_mem("R8 R4 copy32 image");
  endtask

  task automatic t_copy16();
    int n;
    init_mem();
    model(0, 2, 3, 'h482, 3, 'h082, 5, 0, 1, 1);
    launch(0, 2, 3, 'h482, 1, 'h082, 3, 0, 1, 1);
    wait_done(n);
    cmp_mem("R8 R11 copy16 image");
  endtask

  task automatic t_conv(input int w, input int h, input int dbase, input int dstride, input int dfmt,
                        input int sbase, input int sstride, input int sfmt, input string req);
    int n;
    init_mem();
    model(1, w, h, dbase, dstride, sbase, sstride, 0, dfmt, sfmt);
    launch(1, w, h, dbase, dstride - w, sbase, sstride - w, 0, dfmt, sfmt);
    wait_done(n);
    chk(wr_cnt == w * h, "R3 convert write count", wr_cnt, w * h);
    cmp_mem(req);
  endtask

  task automatic t_empty(input int mode, input int w, input int h, input string req);
    int n;
    init_mem();
    launch(mode, w, h, 'h100, 0, 'h200, 0, 32'hffffffff, 0, 0);
    wait_done(n);
    chk(n == 1, {req, " done timing"}, n, 1);
    repeat (3) @(negedge clk);
    chk(wr_cnt == 0, {req, " no writes"}, wr_cnt, 0);
    cmp_mem({req, " memory untouched"});
  endtask

  task automatic t_reprogram();
    int n;
    init_mem();
    model(3, 4, 2, 'hc00, 4, 0, 0, 32'hcafef00d, 0, 0);
    launch(3, 4, 2, 'hc00, 0, 0, 0, 32'hcafef00d, 0, 0);
    reg_wr(3'd6, 32'h0badbeef);
    reg_wr(3'd1, (1 << 16) | 1);
    reg_wr(3'd0, 32'h31);
    wait_done(n);
    repeat (6) @(negedge clk);
    chk(wr_cnt == 8, "R2 restart while busy ignored", wr_cnt, 8);
    cmp_mem("R12 captured settings image");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rd_q = '0;
    init_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill32();
    t_fill16(1, 32'h00c87f3a, 'h202, 3, 2, 6, "R6 R11 rgb565 fill image");
    t_fill16(2, 32'hff9a5c37, 'h300, 1, 3, 4, "R7 argb4444 fill image");
    t_copy32();
    t_copy16();
    t_conv(4, 2, 'h600, 10, 1, 'h000, 4, 0, "R9 32 to rgb565 image");
    t_conv(3, 2, 'h700, 5, 2, 'h040, 6, 0, "R9 32 to argb4444 image");
    t_conv(3, 2, 'ha00, 5, 0, 'h800, 3, 2, "R9 argb4444 to 32 image");
    t_conv(2, 2, 'ha80, 3, 0, 'h802, 4, 1, "R9 rgb565 to 32 image");
    t_empty(3, 0, 4, "R10 zero width");
    t_empty(1, 4, 0, "R10 zero lines");
    t_empty(2, 2, 2, "R10 blend mode");
    t_reprogram();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule